// File: doc/BRIEF.md
# Packet Fragment Forwarder

This block sits between per-port packet storage and a set of egress ports. Bytes reach it from three sources: the main ingress path, a redirect path and an insert path. Each byte carries its logical port number and its start, end and error flags. Accepted bytes go into a small queue for their logical port. While bytes collect, the block marks fragment boundaries. A fragment closes on the last byte of a packet, or once a programmable number of bytes has gathered since the packet began or since the previous boundary.

When egress is idle, a selector picks one logical port. That port must hold at least one closed fragment, and its egress port must not be blocked. The egress port is found through two tables. The logical port indexes a link-identifier table, and the identifier indexes a 64-entry descriptor table that holds the egress port number. Once a fragment has been chosen, it streams out one byte per cycle with no break. Each output byte carries the egress port, the logical port and the byte's own flags. Both tables are written through simple configuration strobes.

Top module: `frag_forwarder`

## Requirements
- R1: While reset is held, and after reset with no source valid, `outValid` is 0 and `srcReady` is all zeros.
- R2: Source 0 outranks source 1, and source 1 outranks source 2. At most one `srcReady` bit is set, only for a valid source, and never while a higher-ranked source is valid.
- R3: While the queue of the addressed logical port holds 16 bytes, the granted source sees `srcReady` low, and no byte is lost.
- R4: The egress port of a fragment is `descTab[lidTab[lport]]`. After reset, `lidTab[i]=i` and `descTab[j]=j mod 2`. A table write takes effect for fragments selected after it.
- R5: The bytes of a logical port leave in arrival order with their data unchanged. `outFragEnd` marks the last byte of each packet.
- R6: `outFragEnd` also marks every byte that completes `fragThresh` bytes, counted from the start of the packet or from the previous boundary. A value of 0 or more than 16 acts as 16.
- R7: Within a packet that is cut into several fragments, `outSop` is set only on the packet's first byte and `outEop` only on its last byte.
- R8: The error flag of each byte is reproduced on `outErr` with that byte.
- R9: A logical port whose egress port has its `egBlocked` bit set in the selection cycle is not started. Other logical ports are still served.
- R10: Among eligible logical ports, the search begins at the port after the one served last (round robin, starting at port 0).
- R11: From the first byte of a fragment to its `outFragEnd` byte, `outValid` stays high and `outLport` and `outPort` hold steady. At least one idle cycle follows each fragment.
- R12: With egress idle, when the byte that closes a fragment is accepted at clock edge E, the fragment's first byte is visible on the outputs after edge E+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcValid | input | 3 | Byte offered by each source (bit 0 = main, 1 = redirect, 2 = insert) |
| srcLport | input | 6 | Logical port per source, 2 bits each |
| srcData | input | 24 | Data byte per source, 8 bits each |
| srcSop | input | 3 | Packet-start flag per source |
| srcEop | input | 3 | Packet-end flag per source |
| srcErr | input | 3 | Error flag per source |
| srcReady | output | 3 | Byte accepted from that source at this edge |
| fragThresh | input | 5 | Fragment size in bytes (0 means 16) |
| egBlocked | input | 2 | Per egress port: do not start a fragment |
| cfgLidWe | input | 1 | Write strobe for the link-identifier table |
| cfgLidAddr | input | 2 | Logical port to write |
| cfgLidData | input | 6 | Link identifier value |
| cfgDescWe | input | 1 | Write strobe for the descriptor table |
| cfgDescAddr | input | 6 | Link identifier to write |
| cfgDescData | input | 1 | Egress port value |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output data byte |
| outPort | output | 1 | Egress port of the byte |
| outLport | output | 2 | Logical port of the byte |
| outSop | output | 1 | Packet start |
| outEop | output | 1 | Packet end |
| outErr | output | 1 | Error flag |
| outFragEnd | output | 1 | Last byte of a fragment |

## Verification
A byte is accepted on the edge that follows the cycle in which its `srcReady` is high. The bench reads `srcReady` half a cycle before that edge, so grant and back-pressure checks see the value that decides the edge. The first byte of a fragment shows two edges after the byte that closes it. The bench therefore checks `outValid` at the first and second falling edges after such an accept, where it must be low and then high. Every later output byte is compared at falling edges against a queue of expected bytes, in the order the requirements fix, so order, flags, port and the gap-free streaming rule are all checked byte by byte.

// File: rtl/pff_pkg.sv
package pff_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_SRC = 3;
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int NUM_LP  = 4;
  localparam int LP_W    = $clog2(NUM_LP);
  localparam int DEPTH   = 16;                 // power of two
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int NUM_LID = 64;
  localparam int LID_W   = $clog2(NUM_LID);
  localparam int NUM_EG  = 2;
  localparam int EG_W    = (NUM_EG > 1) ? $clog2(NUM_EG) : 1;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              sop;
    logic              eop;
    logic              err;
    logic              fragEnd;
  } entry_t;

  typedef struct packed {
    logic             wrEn;
    logic [SRC_W-1:0] wrSrc;
    logic [LP_W-1:0]  wrLp;
    logic             rdEn;
    logic [LP_W-1:0]  rdLp;
    logic [EG_W-1:0]  egPort;
  } strobe_t;
endpackage

// File: rtl/pff_datapath.sv
module pff_datapath
  import pff_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [NUM_SRC*DATA_W-1:0] srcData,
  input  logic [NUM_SRC-1:0]        srcSop,
  input  logic [NUM_SRC-1:0]        srcEop,
  input  logic [NUM_SRC-1:0]        srcErr,
  input  logic [CNT_W-1:0]          fragThresh,
  output logic [NUM_LP-1:0]         lpFull,
  output logic [NUM_LP-1:0]         fragAvail,
  output logic                      headFragEnd,
  output logic                      outValid,
  output logic [DATA_W-1:0]         outData,
  output logic [EG_W-1:0]           outPort,
  output logic [LP_W-1:0]           outLport,
  output logic                      outSop,
  output logic                      outEop,
  output logic                      outErr,
  output logic                      outFragEnd
);
  logic [DATA_W-1:0] wrData;
  logic              wrSop, wrEop, wrErr;
  logic [CNT_W-1:0]  thrEff;
  entry_t            headEnt [NUM_LP];

  assign wrData = srcData[stb.wrSrc*DATA_W +: DATA_W];
  assign wrSop  = srcSop[stb.wrSrc];
  assign wrEop  = srcEop[stb.wrSrc];
  assign wrErr  = srcErr[stb.wrSrc];
  assign thrEff = (fragThresh == '0 || fragThresh > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : fragThresh;

  for (genvar i = 0; i < NUM_LP; i++) begin : g_lane
    logic [PTR_W-1:0] wrPtr, rdPtr;
    logic [CNT_W-1:0] used, accCnt, fragCnt;
    entry_t           mem [DEPTH];
    logic             wrHere, rdHere, closes, rdDone;

    assign wrHere = stb.wrEn && (stb.wrLp == LP_W'(i));
    assign rdHere = stb.rdEn && (stb.rdLp == LP_W'(i));
    assign closes = wrEop || ((accCnt + CNT_W'(1)) == thrEff);
    assign headEnt[i] = mem[rdPtr];
    assign rdDone = rdHere && headEnt[i].fragEnd;
    assign lpFull[i]    = (used == CNT_W'(DEPTH));
    assign fragAvail[i] = (fragCnt != '0);

    always_ff @(posedge clk) begin
      if (wrHere) mem[wrPtr] <= '{data: wrData, sop: wrSop, eop: wrEop, err: wrErr, fragEnd: closes};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrPtr   <= '0;
        rdPtr   <= '0;
        used    <= '0;
        accCnt  <= '0;
        fragCnt <= '0;
      end else begin
        if (wrHere) begin
          wrPtr  <= wrPtr + PTR_W'(1);
          accCnt <= closes ? '0 : accCnt + CNT_W'(1);
        end
        if (rdHere) rdPtr <= rdPtr + PTR_W'(1);
        used    <= used + CNT_W'(wrHere) - CNT_W'(rdHere);
        fragCnt <= fragCnt + CNT_W'(wrHere && closes) - CNT_W'(rdDone);
      end
    end
  end

  assign headFragEnd = headEnt[stb.rdLp].fragEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outData    <= '0;
      outPort    <= '0;
      outLport   <= '0;
      outSop     <= 1'b0;
      outEop     <= 1'b0;
      outErr     <= 1'b0;
      outFragEnd <= 1'b0;
    end else begin
      outValid <= stb.rdEn;
      if (stb.rdEn) begin
        outData    <= headEnt[stb.rdLp].data;
        outSop     <= headEnt[stb.rdLp].sop;
        outEop     <= headEnt[stb.rdLp].eop;
        outErr     <= headEnt[stb.rdLp].err;
        outFragEnd <= headEnt[stb.rdLp].fragEnd;
        outPort    <= stb.egPort;
        outLport   <= stb.rdLp;
      end
    end
  end
endmodule

// File: rtl/pff_ctrl.sv
module pff_ctrl
  import pff_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_SRC-1:0]      srcValid,
  input  logic [NUM_SRC*LP_W-1:0] srcLport,
  input  logic [NUM_LP-1:0]       lpFull,
  input  logic [NUM_LP-1:0]       fragAvail,
  input  logic                    headFragEnd,
  input  logic [NUM_EG-1:0]       egBlocked,
  input  logic                    cfgLidWe,
  input  logic [LP_W-1:0]         cfgLidAddr,
  input  logic [LID_W-1:0]        cfgLidData,
  input  logic                    cfgDescWe,
  input  logic [LID_W-1:0]        cfgDescAddr,
  input  logic [EG_W-1:0]         cfgDescData,
  output strobe_t                 stb,
  output logic [NUM_SRC-1:0]      srcReady
);
  logic [LID_W-1:0] lidTab  [NUM_LP];
  logic [EG_W-1:0]  descTab [NUM_LID];
  logic [EG_W-1:0]  portOf  [NUM_LP];
  logic [NUM_LP-1:0] eligible;

  logic             haveWin, accept;
  logic [SRC_W-1:0] winIdx;
  logic [LP_W-1:0]  winLp;

  logic             busy, found;
  logic [LP_W-1:0]  curLp, rrPtr, pick;
  logic [EG_W-1:0]  curPort;

  // fixed-priority input arbitration
  always_comb begin
    haveWin = 1'b0;
    winIdx  = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (!haveWin && srcValid[s]) begin
        haveWin = 1'b1;
        winIdx  = SRC_W'(s);
      end
    end
  end
  assign winLp    = srcLport[winIdx*LP_W +: LP_W];
  assign accept   = haveWin && !lpFull[winLp];
  assign srcReady = accept ? (NUM_SRC'(1) << winIdx) : '0;

  // two-level port resolution and eligibility
  for (genvar i = 0; i < NUM_LP; i++) begin : g_elig
    assign portOf[i]   = descTab[lidTab[i]];
    assign eligible[i] = fragAvail[i] && !egBlocked[portOf[i]];
  end

  // round-robin search starting at rrPtr
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NUM_LP; k++) begin
      int idx;
      idx = (int'(rrPtr) + k) % NUM_LP;
      if (!found && eligible[idx]) begin
        found = 1'b1;
        pick  = LP_W'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      curLp   <= '0;
      curPort <= '0;
      rrPtr   <= '0;
    end else if (!busy) begin
      if (found) begin
        busy    <= 1'b1;
        curLp   <= pick;
        curPort <= portOf[pick];
        rrPtr   <= LP_W'((int'(pick) + 1) % NUM_LP);
      end
    end else if (headFragEnd) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LP; i++) lidTab[i] <= LID_W'(i);
      for (int j = 0; j < NUM_LID; j++) descTab[j] <= EG_W'(j % NUM_EG);
    end else begin
      if (cfgLidWe)  lidTab[cfgLidAddr]   <= cfgLidData;
      if (cfgDescWe) descTab[cfgDescAddr] <= cfgDescData;
    end
  end

  assign stb.wrEn   = accept;
  assign stb.wrSrc  = winIdx;
  assign stb.wrLp   = winLp;
  assign stb.rdEn   = busy;
  assign stb.rdLp   = curLp;
  assign stb.egPort = curPort;
endmodule

// File: rtl/frag_forwarder.sv
module frag_forwarder
  import pff_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        srcValid,
  input  logic [NUM_SRC*LP_W-1:0]   srcLport,
  input  logic [NUM_SRC*DATA_W-1:0] srcData,
  input  logic [NUM_SRC-1:0]        srcSop,
  input  logic [NUM_SRC-1:0]        srcEop,
  input  logic [NUM_SRC-1:0]        srcErr,
  output logic [NUM_SRC-1:0]        srcReady,
  input  logic [CNT_W-1:0]          fragThresh,
  input  logic [NUM_EG-1:0]         egBlocked,
  input  logic                      cfgLidWe,
  input  logic [LP_W-1:0]           cfgLidAddr,
  input  logic [LID_W-1:0]          cfgLidData,
  input  logic                      cfgDescWe,
  input  logic [LID_W-1:0]          cfgDescAddr,
  input  logic [EG_W-1:0]           cfgDescData,
  output logic                      outValid,
  output logic [DATA_W-1:0]         outData,
  output logic [EG_W-1:0]           outPort,
  output logic [LP_W-1:0]           outLport,
  output logic                      outSop,
  output logic                      outEop,
  output logic                      outErr,
  output logic                      outFragEnd
);
  strobe_t           stb;
  logic [NUM_LP-1:0] lpFull, fragAvail;
  logic              headFragEnd;

  pff_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcLport(srcLport),
    .lpFull(lpFull), .fragAvail(fragAvail), .headFragEnd(headFragEnd),
    .egBlocked(egBlocked), .cfgLidWe(cfgLidWe), .cfgLidAddr(cfgLidAddr),
    .cfgLidData(cfgLidData), .cfgDescWe(cfgDescWe), .cfgDescAddr(cfgDescAddr),
    .cfgDescData(cfgDescData), .stb(stb), .srcReady(srcReady)
  );

  pff_datapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .srcData(srcData), .srcSop(srcSop),
    .srcEop(srcEop), .srcErr(srcErr), .fragThresh(fragThresh),
    .lpFull(lpFull), .fragAvail(fragAvail), .headFragEnd(headFragEnd),
    .outValid(outValid), .outData(outData), .outPort(outPort),
    .outLport(outLport), .outSop(outSop), .outEop(outEop), .outErr(outErr),
    .outFragEnd(outFragEnd)
  );
endmodule

// File: rtl/frag_forwarder_chk.sv
module frag_forwarder_chk
  import pff_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_SRC-1:0]   srcValid,
  input logic [NUM_SRC-1:0]   srcReady,
  input logic [NUM_EG-1:0]    egBlocked,
  input logic                 outValid,
  input logic [EG_W-1:0]      outPort,
  input logic [LP_W-1:0]      outLport,
  input logic                 outSop,
  input logic                 outFragEnd
);
  logic [NUM_EG-1:0] blk1, blk2;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blk1 <= '0;
      blk2 <= '0;
    end else begin
      blk1 <= egBlocked;
      blk2 <= blk1;
    end
  end

  always_comb begin
    if (!rstN) AST_RESET_QUIET: assert (!outValid); // R1
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(srcReady)); // R2
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN) (srcReady & ~srcValid) == '0); // R2

  for (genvar s = 1; s < NUM_SRC; s++) begin : g_prio
    AST_PRIO_ORDER: assert property (@(posedge clk) disable iff (!rstN)
      srcReady[s] |-> (srcValid[s-1:0] == '0)); // R2
  end

  AST_FRAG_UNBROKEN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outFragEnd) |=> (outValid && $stable(outLport) && $stable(outPort))); // R11
  AST_GAP_AFTER_FRAG: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFragEnd) |=> !outValid); // R11
  AST_SOP_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSop) |-> !$past(outValid)); // R7
  AST_NOT_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> !blk2[outPort]); // R9
endmodule

bind frag_forwarder frag_forwarder_chk chk_i (
  .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcReady(srcReady),
  .egBlocked(egBlocked), .outValid(outValid), .outPort(outPort),
  .outLport(outLport), .outSop(outSop), .outFragEnd(outFragEnd)
);

// File: tb/frag_forwarder_tb_top.sv
`timescale 1ns/1ps
module frag_forwarder_tb_top;
  import pff_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_SRC-1:0]        srcValid = '0;
  logic [NUM_SRC*LP_W-1:0]   srcLport = '0;
  logic [NUM_SRC*DATA_W-1:0] srcData  = '0;
  logic [NUM_SRC-1:0]        srcSop = '0, srcEop = '0, srcErr = '0;
  logic [NUM_SRC-1:0]        srcReady;
  logic [CNT_W-1:0]          fragThresh = '0;
  logic [NUM_EG-1:0]         egBlocked = '0;
  logic                      cfgLidWe = 1'b0, cfgDescWe = 1'b0;
  logic [LP_W-1:0]           cfgLidAddr = '0;
  logic [LID_W-1:0]          cfgLidData = '0, cfgDescAddr = '0;
  logic [EG_W-1:0]           cfgDescData = '0;
  logic                      outValid, outSop, outEop, outErr, outFragEnd;
  logic [DATA_W-1:0]         outData;
  logic [EG_W-1:0]           outPort;
  logic [LP_W-1:0]           outLport;

  always #2.5 clk = ~clk;

  frag_forwarder dut_i (.*);

  typedef struct {
    logic [DATA_W-1:0] data;
    logic [EG_W-1:0]   port;
    logic [LP_W-1:0]   lp;
    logic              sop, eop, err, fe;
    string             req;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   errors = 0;
  logic [EG_W-1:0] expPort [NUM_LP];
  logic prevValid = 1'b0, prevFe = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (prevValid && !prevFe) check(outValid == 1'b1, "R11", "stream gap", outValid, 1);
      if (prevValid && prevFe)  check(outValid == 1'b0, "R11", "idle after fragment", outValid, 0);
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9", "unexpected byte", {outLport, outData}, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check({outData, outPort, outLport, outSop, outEop, outErr, outFragEnd} ==
                {e.data, e.port, e.lp, e.sop, e.eop, e.err, e.fe}, e.req, "output byte",
                int'({outData, outPort, outLport, outSop, outEop, outErr, outFragEnd}),
                int'({e.data, e.port, e.lp, e.sop, e.eop, e.err, e.fe}));
        end
      end
      prevValid = outValid;
      prevFe    = outFragEnd;
    end
  end

  task automatic pushBytes(input int lp, input int n, input int base, input bit sopFirst,
                           input bit eopLast, input bit errLast, input int thr, input string req);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.data = DATA_W'(base + k);
      e.port = expPort[lp];
      e.lp   = LP_W'(lp);
      e.sop  = sopFirst && (k == 0);
      e.eop  = eopLast && (k == n - 1);
      e.err  = errLast && (k == n - 1);
      e.fe   = (((k + 1) % thr) == 0) || (eopLast && (k == n - 1));
      e.req  = req;
      expQ.push_back(e);
    end
  endtask

  // drives n bytes; returns right after the posedge that accepts the last one
  task automatic drivePkt(input int src, input int lp, input int n, input int base,
                          input bit sopFirst, input bit eopLast, input bit errLast);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      srcValid[src] = 1'b1;
      srcLport[src*LP_W +: LP_W]     = LP_W'(lp);
      srcData[src*DATA_W +: DATA_W]  = DATA_W'(base + k);
      srcSop[src] = sopFirst && (k == 0);
      srcEop[src] = eopLast && (k == n - 1);
      srcErr[src] = errLast && (k == n - 1);
      #1;
      while (!srcReady[src]) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
  endtask

  task automatic idleSrc();
    @(negedge clk);
    srcValid = '0;
    srcSop = '0;
    srcEop = '0;
    srcErr = '0;
  endtask

  task automatic drain(input string req);
    int waited = 0;
    while ((expQ.size() != 0 || outValid) && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, req, "pending expected bytes", expQ.size(), 0);
  endtask

  task automatic cfgLid(input int lp, input int lid);
    @(negedge clk);
    cfgLidWe = 1'b1; cfgLidAddr = LP_W'(lp); cfgLidData = LID_W'(lid);
    @(negedge clk);
    cfgLidWe = 1'b0;
  endtask

  task automatic cfgDesc(input int lid, input int port);
    @(negedge clk);
    cfgDescWe = 1'b1; cfgDescAddr = LID_W'(lid); cfgDescData = EG_W'(port);
    @(negedge clk);
    cfgDescWe = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NUM_LP; i++) expPort[i] = EG_W'(i % NUM_EG);
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    check(srcReady == '0, "R1", "srcReady after reset", srcReady, 0);

    // R12 latency, R5 single-byte packet, R8 error flag
    pushBytes(0, 1, 8'hA5, 1, 1, 1, DEPTH, "R8");
    drivePkt(0, 0, 1, 8'hA5, 1, 1, 1);
    idleSrc();
    @(negedge clk);
    check(outValid == 1'b0, "R12", "outValid one edge after accept", outValid, 0);
    @(negedge clk);
    check(outValid == 1'b1, "R12", "outValid two edges after accept", outValid, 1);
    drain("R12");

    // R5 multi-byte packet, default mapping (R4)
    pushBytes(1, 5, 8'h10, 1, 1, 0, DEPTH, "R5");
    drivePkt(1, 1, 5, 8'h10, 1, 1, 0);
    idleSrc();
    drain("R5");

    // R6/R7 threshold fragments 3+3+1
    fragThresh = 5'd3;
    pushBytes(2, 7, 8'h20, 1, 1, 1, 3, "R6");
    drivePkt(2, 2, 7, 8'h20, 1, 1, 1);
    idleSrc();
    drain("R7");
    fragThresh = 5'd0;

    // R2 fixed priority
    pushBytes(0, 1, 8'h40, 1, 1, 0, DEPTH, "R2");
    pushBytes(1, 1, 8'h50, 1, 1, 0, DEPTH, "R2");
    pushBytes(2, 1, 8'h60, 1, 1, 0, DEPTH, "R2");
    @(negedge clk);
    srcValid = 3'b111;
    srcLport = {2'd2, 2'd1, 2'd0};
    srcData  = {8'h60, 8'h50, 8'h40};
    srcSop = 3'b111; srcEop = 3'b111; srcErr = 3'b000;
    #1;
    check(srcReady == 3'b001, "R2", "grant with all valid", srcReady, 1);
    @(negedge clk);
    srcValid[0] = 1'b0;
    #1;
    check(srcReady == 3'b010, "R2", "grant to redirect", srcReady, 2);
    @(negedge clk);
    srcValid[1] = 1'b0;
    #1;
    check(srcReady == 3'b100, "R2", "grant to insert", srcReady, 4);
    idleSrc();
    drain("R2");

    // R4 two-level mapping
    cfgLid(2, 41);
    expPort[2] = 1'b1;
    pushBytes(2, 2, 8'h70, 1, 1, 0, DEPTH, "R4");
    drivePkt(0, 2, 2, 8'h70, 1, 1, 0);
    idleSrc();
    drain("R4");
    cfgDesc(41, 0);
    expPort[2] = 1'b0;
    pushBytes(2, 2, 8'h78, 1, 1, 0, DEPTH, "R4");
    drivePkt(0, 2, 2, 8'h78, 1, 1, 0);
    idleSrc();
    drain("R4");

    // R9 blocked egress port 1 holds LP1, LP0 still served
    egBlocked = 2'b10;
    drivePkt(0, 1, 2, 8'h80, 1, 1, 0);
    pushBytes(0, 2, 8'h88, 1, 1, 0, DEPTH, "R9");
    drivePkt(0, 0, 2, 8'h88, 1, 1, 0);
    idleSrc();
    drain("R9");
    repeat (8) begin
      @(negedge clk);
      check(outValid == 1'b0, "R9", "blocked port stays idle", outValid, 0);
    end
    pushBytes(1, 2, 8'h80, 1, 1, 0, DEPTH, "R9");
    egBlocked = 2'b00;
    drain("R9");

    // R10 round robin: last served LP1, so order is LP3, LP0, LP1
    egBlocked = 2'b11;
    drivePkt(0, 0, 1, 8'h90, 1, 1, 0);
    drivePkt(0, 1, 1, 8'h91, 1, 1, 0);
    drivePkt(0, 3, 1, 8'h93, 1, 1, 0);
    idleSrc();
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R9", "all ports blocked", outValid, 0);
    pushBytes(3, 1, 8'h93, 1, 1, 0, DEPTH, "R10");
    pushBytes(0, 1, 8'h90, 1, 1, 0, DEPTH, "R10");
    pushBytes(1, 1, 8'h91, 1, 1, 0, DEPTH, "R10");
    egBlocked = 2'b00;
    drain("R10");

    // R3 full queue, R6 default threshold of 16, R7 flags on split packet
    egBlocked = 2'b10;
    drivePkt(1, 3, 16, 8'hB0, 1, 0, 0);
    @(negedge clk);
    srcValid[1] = 1'b1;
    srcLport[1*LP_W +: LP_W] = 2'd3;
    srcData[1*DATA_W +: DATA_W] = 8'hC0;
    srcSop[1] = 1'b0; srcEop[1] = 1'b1; srcErr[1] = 1'b0;
    for (int c = 0; c < 3; c++) begin
      #1;
      check(srcReady == 3'b000, "R3", "ready while queue full", srcReady, 0);
      @(negedge clk);
    end
    srcValid = '0;
    srcEop = '0;
    pushBytes(3, 16, 8'hB0, 1, 0, 0, DEPTH, "R6");
    egBlocked = 2'b00;
    drain("R3");
    pushBytes(3, 1, 8'hC0, 0, 1, 0, DEPTH, "R7");
    drivePkt(1, 3, 1, 8'hC0, 0, 1, 0);
    idleSrc();
    drain("R7");

    check(expQ.size() == 0, "R5", "scoreboard empty at end", expQ.size(), 0);
    finishRun();
  end
endmodule